// File: doc/BRIEF.md
# Per-Thread Pipeline Squash Arbiter

This block sits beside the reorder buffer of a multithreaded out-of-order core. Each cycle and for each hardware thread it decides whether a pipeline squash is taken. It then computes the sequence-number boundaries and the redirect target that are broadcast to the earlier stages. Three kinds of request reach it. A delayed trap request and a thread-context request both flush the whole thread. A request from the execute stage flushes everything younger than a given instruction. That request carries the instruction's sequence number, an include-self flag, mispredict and taken flags, and a conditional-delay-slot flag.

For each thread the block tracks the youngest valid sequence number held in the reorder buffer. It uses this value to reject squashes that come from instructions already removed by an older squash. Each thread is in one of three states: running, waiting for a trap, or squashing. While a thread squashes, the block keeps asserting a busy flag to the rest of the pipeline until the reorder buffer reports that its walk is finished. Instructions that arrive for a squashing thread are dropped. The reorder buffer's own walk is not part of this block.

All outputs are registered. Inputs presented in one cycle show up on the outputs after the next rising clock edge. The sequence number (16 bits) and the PC (32 bits) are fixed in the shared package. The thread count and the counter width are parameters.

Top module: `sqarb_top`

## Requirements
- R1: After synchronous reset every thread is running, and every output is zero: flags, boundaries, done sequence, redirect PC, youngest sequence and mispredict count.
- R2: A trap request or a context request, alone or both together, takes a full squash. The boundary and done sequence both equal the ROB head sequence minus one, or zero when the ROB is empty. The redirect PC is the thread's architectural PC, the youngest sequence becomes zero, and the thread enters squashing with the busy flag set.
- R3: An execute squash is accepted only when the thread is not waiting for a trap and its sequence number is less than or equal to the youngest tracked sequence. A rejected request raises no fire pulse and leaves the youngest sequence unchanged.
- R4: On an accepted execute squash the done sequence is the request sequence. When include-self is set, both the done sequence and the boundary are one lower.
- R5: The boundary of an accepted execute squash depends on the flags. When mispredict, taken and conditional-delay-slot are all set, the boundary is the request sequence and the delay-slot-kill flag is 1. For any other mispredict the boundary is the sequence plus one and the kill flag is 0. Without a mispredict the boundary is the sequence and the kill flag is 0. In every case the redirect PC is the request's target.
- R6: A thread that takes a squash stays in squashing, with busy high, on every cycle until the ROB walk-done input is seen. It then returns to running on the next edge.
- R7: After an accepted execute squash the youngest tracked sequence is the done sequence. An accepted new instruction sets it to that instruction's sequence number.
- R8: A new instruction for a thread that is squashing and does not see walk-done this cycle is dropped: the accepted pulse stays low and the youngest sequence does not change.
- R9: The per-thread 8-bit mispredict count rises by one for each accepted execute squash whose mispredict flag is set, and wraps modulo 256.
- R10: When a full squash and an execute squash arrive in the same cycle, only the full squash is taken. The kill flag stays 0 and the mispredict count does not change.
- R11: A fault request on a running thread with no squash in that cycle moves it to waiting-for-trap. A later trap request moves it to squashing.
- R12: Threads are independent: requests on one thread never change another thread's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_sq_req | input | NTHR | Delayed trap squash request per thread |
| ctx_sq_req | input | NTHR | Thread-context squash request per thread |
| fault_req | input | NTHR | Committing fault, thread begins waiting for its trap |
| ex_sq_vld | input | NTHR | Execute-stage squash request valid |
| ex_sq_seq | input | NTHR*16 | Sequence number of the squashing instruction |
| ex_incl_self | input | NTHR | Squash includes the instruction itself |
| ex_mispred | input | NTHR | Request is a branch mispredict |
| ex_taken | input | NTHR | Mispredicted branch resolved taken |
| ex_cond_ds | input | NTHR | Branch has a conditional delay slot |
| ex_tgt_pc | input | NTHR*32 | Redirect target of the execute squash |
| arch_pc | input | NTHR*32 | Architectural restart PC for full squashes |
| rob_empty | input | NTHR | ROB holds no instruction of the thread |
| rob_head_seq | input | NTHR*16 | Sequence number at the thread's ROB head |
| rob_walk_done | input | NTHR | ROB has finished the squash walk |
| new_vld | input | NTHR | New instruction offered for insertion |
| new_seq | input | NTHR*16 | Sequence number of the new instruction |
| sq_fire | output | NTHR | Squash taken last cycle (one-cycle pulse) |
| rob_sq_busy | output | NTHR | Thread is squashing |
| rob_bound | output | NTHR*16 | ROB squash boundary |
| done_seq | output | NTHR*16 | Done sequence number broadcast |
| ds_kill | output | NTHR | Delay slot is squashed too |
| redir_pc | output | NTHR*32 | Redirect PC |
| new_taken | output | NTHR | New instruction was accepted |
| young_seq | output | NTHR*16 | Youngest tracked sequence number |
| mispred_cnt | output | NTHR*8 | Accepted mispredict squashes, wrapping |

## Verification
A fixed directed sequence on thread 0 first builds a known youngest sequence by insertion. It then sends execute squashes with sequence numbers just below, equal to and above that value, so acceptance and rejection are told apart at the fire pulse. The four combinations of the mispredict, taken and delay-slot flags, each with and without include-self, separate the three boundary offsets from the done decrement. Full squashes are tried with an empty and a non-empty ROB, and together with a same-cycle execute squash and a pending fault, which shows precedence and the trap-wait rejection. Several thousand cycles of mixed random traffic on both threads then exercise overlapping squashes, insertions during a walk and the cross-thread independence.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;

    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef enum logic [1:0] {
        TH_RUN      = 2'd0,
        TH_TRAPWAIT = 2'd1,
        TH_ROBSQ    = 2'd2
    } th_state_e;

    typedef struct packed {
        logic vld;
        seq_t seq;
        logic incl_self;
        logic mispred;
        logic taken;
        logic cond_ds;
        pc_t  tgt;
    } ex_req_t;

    typedef struct packed {
        logic empty;
        seq_t head;
        logic walk_done;
    } rob_view_t;

    typedef struct packed {
        logic fire;
        logic ds_kill;
        seq_t bound;
        seq_t done;
        pc_t  pc;
    } sq_bcast_t;

    // Boundary for a whole-thread flush.
    function automatic seq_t full_boundary(input logic empty, input seq_t head);
        return empty ? '0 : head - seq_t'(1);
    endfunction

    // Broadcast for an execute-stage squash; boundary offset is one of -1, 0, +1, +0.
    function automatic sq_bcast_t resolve_ex(input ex_req_t r);
        sq_bcast_t o;
        logic      keep_slot;
        seq_t      b_off;
        keep_slot = r.mispred && !(r.taken && r.cond_ds);
        case ({keep_slot, r.incl_self})
            2'b10:   b_off = seq_t'(1);
            2'b01:   b_off = '1;
            default: b_off = '0;
        endcase
        o.fire    = 1'b1;
        o.ds_kill = r.mispred && r.taken && r.cond_ds;
        o.bound   = r.seq + b_off;
        o.done    = r.incl_self ? r.seq - seq_t'(1) : r.seq;
        o.pc      = r.tgt;
        return o;
    endfunction

endpackage

// File: rtl/sqarb_evt_ctr.sv
module sqarb_evt_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9: the count moves by one exactly when an event is signalled
    p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
        inc |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !inc |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/sqarb_thread.sv
module sqarb_thread
    import sqarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trap_req,
    input  logic      ctx_req,
    input  logic      fault_req,
    input  ex_req_t   ex,
    input  pc_t       arch_pc,
    input  rob_view_t rob,
    input  logic      new_vld,
    input  seq_t      new_seq,
    output sq_bcast_t bc_q,
    output logic      rob_busy_q,
    output logic      new_ok_q,
    output seq_t      young_q,
    output logic      mis_evt
);
    th_state_e state_q, state_n;
    sq_bcast_t bc_n;
    seq_t      young_n;
    logic      new_ok_n;
    logic      take_full, ex_ok, take_ex;
    sq_bcast_t ex_bc;

    always_comb begin
        take_full = trap_req || ctx_req;
        ex_ok     = ex.vld && (state_q != TH_TRAPWAIT) && (ex.seq <= young_q);
        take_ex   = !take_full && ex_ok;
        ex_bc     = resolve_ex(ex);

        state_n      = state_q;
        young_n      = young_q;
        new_ok_n     = 1'b0;
        mis_evt      = 1'b0;
        bc_n         = bc_q;
        bc_n.fire    = 1'b0;
        bc_n.ds_kill = 1'b0;

        if (take_full) begin
            bc_n.fire  = 1'b1;
            bc_n.bound = full_boundary(rob.empty, rob.head);
            bc_n.done  = full_boundary(rob.empty, rob.head);
            bc_n.pc    = arch_pc;
            young_n    = '0;
            state_n    = TH_ROBSQ;
        end else if (take_ex) begin
            bc_n    = ex_bc;
            young_n = ex_bc.done;
            state_n = TH_ROBSQ;
            mis_evt = ex.mispred;
        end else begin
            if (state_q == TH_ROBSQ && rob.walk_done)
                state_n = TH_RUN;
            else if (state_q == TH_RUN && fault_req)
                state_n = TH_TRAPWAIT;
            if (state_n != TH_ROBSQ && new_vld) begin
                young_n  = new_seq;
                new_ok_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= TH_RUN;
            bc_q       <= '0;
            young_q    <= '0;
            new_ok_q   <= 1'b0;
            rob_busy_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            bc_q       <= bc_n;
            young_q    <= young_n;
            new_ok_q   <= new_ok_n;
            rob_busy_q <= (state_n == TH_ROBSQ);
        end
    end

    // R2: whole-thread flush broadcast
    p_full_flush_r2: assert property (@(posedge clk) disable iff (rst)
        (trap_req || ctx_req) |=> bc_q.fire && !bc_q.ds_kill && young_q == '0
                                  && rob_busy_q && bc_q.pc == $past(arch_pc));
    p_full_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (trap_req || ctx_req) && rob.empty |=> bc_q.bound == '0 && bc_q.done == '0);
    // R3: stale or trap-blocked execute squash gives no pulse
    p_reject_r3: assert property (@(posedge clk) disable iff (rst)
        !trap_req && !ctx_req && ex.vld && (state_q == TH_TRAPWAIT || ex.seq > young_q)
        |=> !bc_q.fire);
    // R4: include-self lowers the done sequence
    p_incl_r4: assert property (@(posedge clk) disable iff (rst)
        !trap_req && !ctx_req && ex.vld && state_q != TH_TRAPWAIT && ex.seq <= young_q
        && ex.incl_self |=> bc_q.done == $past(ex.seq) - seq_t'(1));
    // R5: taken branch with conditional delay slot kills the slot
    p_ds_kill_r5: assert property (@(posedge clk) disable iff (rst)
        !trap_req && !ctx_req && ex.vld && state_q != TH_TRAPWAIT && ex.seq <= young_q
        && ex.mispred && ex.taken && ex.cond_ds && !ex.incl_self
        |=> bc_q.ds_kill && bc_q.bound == $past(ex.seq));
    // R6: busy holds until the walk completes
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == TH_ROBSQ && !rob.walk_done |=> rob_busy_q);
    // R8: insertions during a walk are dropped
    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        rob_busy_q && !rob.walk_done && new_vld && !trap_req && !ctx_req && !ex.vld
        |=> !new_ok_q && $stable(young_q));
endmodule

// File: rtl/sqarb_top.sv
module sqarb_top
    import sqarb_pkg::*;
#(
    parameter int NTHR  = 2,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTHR-1:0]       trap_sq_req,
    input  logic [NTHR-1:0]       ctx_sq_req,
    input  logic [NTHR-1:0]       fault_req,
    input  logic [NTHR-1:0]       ex_sq_vld,
    input  logic [NTHR*SEQ_W-1:0] ex_sq_seq,
    input  logic [NTHR-1:0]       ex_incl_self,
    input  logic [NTHR-1:0]       ex_mispred,
    input  logic [NTHR-1:0]       ex_taken,
    input  logic [NTHR-1:0]       ex_cond_ds,
    input  logic [NTHR*PC_W-1:0]  ex_tgt_pc,
    input  logic [NTHR*PC_W-1:0]  arch_pc,
    input  logic [NTHR-1:0]       rob_empty,
    input  logic [NTHR*SEQ_W-1:0] rob_head_seq,
    input  logic [NTHR-1:0]       rob_walk_done,
    input  logic [NTHR-1:0]       new_vld,
    input  logic [NTHR*SEQ_W-1:0] new_seq,
    output logic [NTHR-1:0]       sq_fire,
    output logic [NTHR-1:0]       rob_sq_busy,
    output logic [NTHR*SEQ_W-1:0] rob_bound,
    output logic [NTHR*SEQ_W-1:0] done_seq,
    output logic [NTHR-1:0]       ds_kill,
    output logic [NTHR*PC_W-1:0]  redir_pc,
    output logic [NTHR-1:0]       new_taken,
    output logic [NTHR*SEQ_W-1:0] young_seq,
    output logic [NTHR*CNT_W-1:0] mispred_cnt
);
    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        ex_req_t   exr;
        rob_view_t rv;
        sq_bcast_t bc;
        logic      mis;
        logic      busy, nok;
        seq_t      yng;

        assign exr.vld       = ex_sq_vld[g];
        assign exr.seq       = ex_sq_seq[g*SEQ_W +: SEQ_W];
        assign exr.incl_self = ex_incl_self[g];
        assign exr.mispred   = ex_mispred[g];
        assign exr.taken     = ex_taken[g];
        assign exr.cond_ds   = ex_cond_ds[g];
        assign exr.tgt       = ex_tgt_pc[g*PC_W +: PC_W];
        assign rv.empty      = rob_empty[g];
        assign rv.head       = rob_head_seq[g*SEQ_W +: SEQ_W];
        assign rv.walk_done  = rob_walk_done[g];

        sqarb_thread u_thr (
            .clk       (clk),
            .rst       (rst),
            .trap_req  (trap_sq_req[g]),
            .ctx_req   (ctx_sq_req[g]),
            .fault_req (fault_req[g]),
            .ex        (exr),
            .arch_pc   (arch_pc[g*PC_W +: PC_W]),
            .rob       (rv),
            .new_vld   (new_vld[g]),
            .new_seq   (new_seq[g*SEQ_W +: SEQ_W]),
            .bc_q      (bc),
            .rob_busy_q(busy),
            .new_ok_q  (nok),
            .young_q   (yng),
            .mis_evt   (mis)
        );

        sqarb_evt_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .inc  (mis),
            .cnt_q(mispred_cnt[g*CNT_W +: CNT_W])
        );

        assign sq_fire[g]                   = bc.fire;
        assign ds_kill[g]                   = bc.ds_kill;
        assign rob_bound[g*SEQ_W +: SEQ_W]  = bc.bound;
        assign done_seq[g*SEQ_W +: SEQ_W]   = bc.done;
        assign redir_pc[g*PC_W +: PC_W]     = bc.pc;
        assign rob_sq_busy[g]               = busy;
        assign new_taken[g]                 = nok;
        assign young_seq[g*SEQ_W +: SEQ_W]  = yng;
    end
endmodule

// File: tb/sim_sqarb_top.sv
`timescale 1ns/1ps
module sim_sqarb_top;
    localparam int NT = 2;
    localparam int SW = 16;
    localparam int PW = 32;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NT-1:0]    trap_sq_req, ctx_sq_req, fault_req, ex_sq_vld;
    logic [NT-1:0]    ex_incl_self, ex_mispred, ex_taken, ex_cond_ds;
    logic [NT*SW-1:0] ex_sq_seq, rob_head_seq, new_seq;
    logic [NT*PW-1:0] ex_tgt_pc, arch_pc;
    logic [NT-1:0]    rob_empty, rob_walk_done, new_vld;
    logic [NT-1:0]    sq_fire, rob_sq_busy, ds_kill, new_taken;
    logic [NT*SW-1:0] rob_bound, done_seq, young_seq;
    logic [NT*PW-1:0] redir_pc;
    logic [NT*CW-1:0] mispred_cnt;

    sqarb_top #(.NTHR(NT), .CNT_W(CW)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int          m_st    [NT];   // 0 run, 1 trap wait, 2 squashing
    logic [15:0] m_young [NT];
    logic [15:0] m_bound [NT];
    logic [15:0] m_done  [NT];
    logic [31:0] m_pc    [NT];
    logic        m_fire  [NT];
    logic        m_ds    [NT];
    logic        m_ins   [NT];
    logic [7:0]  m_cnt   [NT];
    logic [15:0] nseq    [NT];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic clr_in();
        trap_sq_req = '0; ctx_sq_req = '0; fault_req = '0; ex_sq_vld = '0;
        ex_incl_self = '0; ex_mispred = '0; ex_taken = '0; ex_cond_ds = '0;
        ex_sq_seq = '0; rob_head_seq = '0; new_seq = '0; ex_tgt_pc = '0;
        arch_pc = '0; rob_empty = '0; rob_walk_done = '0; new_vld = '0;
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_young[t] = 0; m_bound[t] = 0; m_done[t] = 0;
            m_pc[t] = 0; m_fire[t] = 0; m_ds[t] = 0; m_ins[t] = 0; m_cnt[t] = 0;
        end
    endtask

    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            logic [15:0] es, hd, b;
            es = ex_sq_seq[t*SW +: SW];
            hd = rob_head_seq[t*SW +: SW];
            m_fire[t] = 0; m_ds[t] = 0; m_ins[t] = 0;
            if (trap_sq_req[t] || ctx_sq_req[t]) begin
                m_bound[t] = rob_empty[t] ? 16'd0 : hd - 16'd1;
                m_done[t]  = m_bound[t];
                m_pc[t]    = arch_pc[t*PW +: PW];
                m_fire[t]  = 1; m_young[t] = 0; m_st[t] = 2;
            end else if (ex_sq_vld[t] && m_st[t] != 1 && es <= m_young[t]) begin
                if (ex_mispred[t] && ex_taken[t] && ex_cond_ds[t]) begin
                    b = es; m_ds[t] = 1;
                end else if (ex_mispred[t]) b = es + 16'd1;
                else b = es;
                m_done[t] = es;
                if (ex_incl_self[t]) begin b = b - 16'd1; m_done[t] = es - 16'd1; end
                m_bound[t] = b;
                m_pc[t]    = ex_tgt_pc[t*PW +: PW];
                m_fire[t]  = 1; m_young[t] = m_done[t]; m_st[t] = 2;
                if (ex_mispred[t]) m_cnt[t] = m_cnt[t] + 8'd1;
            end else begin
                if (m_st[t] == 2 && rob_walk_done[t]) m_st[t] = 0;
                else if (m_st[t] == 0 && fault_req[t]) m_st[t] = 1;
                if (m_st[t] != 2 && new_vld[t]) begin
                    m_young[t] = new_seq[t*SW +: SW]; m_ins[t] = 1;
                end
            end
        end
    endtask

    task automatic compare_all();
        for (int t = 0; t < NT; t++) begin
            chk("R3 fire",    sq_fire[t],                m_fire[t]);
            chk("R5 ds_kill", ds_kill[t],                m_ds[t]);
            chk("R5 bound",   rob_bound[t*SW +: SW],     m_bound[t]);
            chk("R4 done",    done_seq[t*SW +: SW],      m_done[t]);
            chk("R2 pc",      redir_pc[t*PW +: PW],      m_pc[t]);
            chk("R6 busy",    rob_sq_busy[t],            m_st[t] == 2);
            chk("R8 accept",  new_taken[t],              m_ins[t]);
            chk("R7 youngest",young_seq[t*SW +: SW],     m_young[t]);
            chk("R9 count",   mispred_cnt[t*CW +: CW],   m_cnt[t]);
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clr_in();
    endtask

    task automatic ins(input int t, input int s);
        new_vld[t] = 1; new_seq[t*SW +: SW] = 16'(s); cyc();
    endtask

    task automatic exq(input int t, input int s, input bit inc, input bit mis,
                       input bit tk, input bit cds, input int pc);
        ex_sq_vld[t] = 1; ex_sq_seq[t*SW +: SW] = 16'(s);
        ex_incl_self[t] = inc; ex_mispred[t] = mis; ex_taken[t] = tk;
        ex_cond_ds[t] = cds; ex_tgt_pc[t*PW +: PW] = 32'(pc);
    endtask

    function automatic longint g16(input logic [NT*SW-1:0] v, input int t);
        return longint'(v[t*SW +: SW]);
    endfunction

    initial begin
        clr_in();
        model_reset();
        for (int t = 0; t < NT; t++) nseq[t] = 16'd100;
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all();
        chk("R1 busy", rob_sq_busy, 0);
        chk("R1 count", mispred_cnt, 0);
        rst = 1'b0;

        for (int s = 10; s <= 20; s++) ins(0, s);
        chk("R7 after insert", g16(young_seq, 0), 20);
        chk("R12 idle thread", g16(young_seq, 1), 0);

        exq(0, 15, 0, 0, 0, 0, 32'h200); cyc();
        chk("R5 plain bound", g16(rob_bound, 0), 15);
        chk("R6 busy set", rob_sq_busy[0], 1);
        chk("R12 other quiet", sq_fire[1], 0);

        ins(0, 30);
        chk("R8 dropped", new_taken[0], 0);
        chk("R8 youngest kept", g16(young_seq, 0), 15);
        rob_walk_done[0] = 1; cyc();
        chk("R6 walk done", rob_sq_busy[0], 0);

        for (int s = 16; s <= 20; s++) ins(0, s);
        exq(0, 25, 0, 1, 0, 0, 32'h300); cyc();
        chk("R3 stale rejected", sq_fire[0], 0);
        chk("R3 youngest kept", g16(young_seq, 0), 20);

        exq(0, 18, 0, 1, 0, 0, 32'h400); cyc();
        chk("R5 slot kept", g16(rob_bound, 0), 19);
        chk("R4 done", g16(done_seq, 0), 18);
        chk("R9 count", mispred_cnt[CW-1:0], 1);

        rob_walk_done[0] = 1; cyc();
        for (int s = 19; s <= 22; s++) ins(0, s);
        exq(0, 20, 0, 1, 1, 1, 32'h500); cyc();
        chk("R5 slot killed", ds_kill[0], 1);
        chk("R5 ds bound", g16(rob_bound, 0), 20);

        rob_walk_done[0] = 1; cyc();
        for (int s = 21; s <= 24; s++) ins(0, s);
        exq(0, 22, 1, 1, 0, 0, 32'h600); cyc();
        chk("R4 incl bound", g16(rob_bound, 0), 22);
        chk("R4 incl done", g16(done_seq, 0), 21);
        chk("R7 youngest", g16(young_seq, 0), 21);

        rob_walk_done[0] = 1; cyc();
        fault_req[0] = 1; cyc();
        exq(0, 10, 0, 0, 0, 0, 32'h700); cyc();
        chk("R11 trapwait rejects", sq_fire[0], 0);
        ins(0, 25);
        chk("R11 insert ok", new_taken[0], 1);
        trap_sq_req[0] = 1; rob_head_seq[SW-1:0] = 16'd5;
        arch_pc[PW-1:0] = 32'h1000; cyc();
        chk("R2 head bound", g16(rob_bound, 0), 4);
        chk("R2 pc", redir_pc[PW-1:0], 32'h1000);
        chk("R11 to squash", rob_sq_busy[0], 1);

        rob_walk_done[0] = 1; cyc();
        ins(0, 3);
        ctx_sq_req[0] = 1; rob_empty[0] = 1; rob_head_seq[SW-1:0] = 16'd9; cyc();
        chk("R2 empty bound", g16(rob_bound, 0), 0);

        rob_walk_done[0] = 1; cyc();
        ins(0, 7);
        trap_sq_req[0] = 1; ctx_sq_req[0] = 1; rob_head_seq[SW-1:0] = 16'd9;
        exq(0, 3, 0, 1, 1, 1, 32'h800); cyc();
        chk("R10 full wins", g16(rob_bound, 0), 8);
        chk("R10 no kill", ds_kill[0], 0);
        chk("R10 no count", mispred_cnt[CW-1:0], 3);

        rob_walk_done[0] = 1;
        new_vld[0] = 1; new_seq[SW-1:0] = 16'd50;
        exq(1, 0, 0, 0, 0, 0, 32'h900); cyc();
        chk("R12 thread1 fire", sq_fire[1], 1);
        chk("R12 thread0 insert", new_taken[0], 1);

        // mixed traffic on both threads
        for (int i = 0; i < 4000; i++) begin
            for (int t = 0; t < NT; t++) begin
                trap_sq_req[t]   = ($urandom_range(0, 39) == 0);
                ctx_sq_req[t]    = ($urandom_range(0, 39) == 0);
                fault_req[t]     = ($urandom_range(0, 29) == 0);
                rob_walk_done[t] = ($urandom_range(0, 2) == 0);
                rob_empty[t]     = ($urandom_range(0, 3) == 0);
                rob_head_seq[t*SW +: SW] = 16'($urandom_range(0, 200));
                arch_pc[t*PW +: PW]      = $urandom;
                if ($urandom_range(0, 1) == 1) begin
                    nseq[t] = nseq[t] + 16'd1;
                    new_vld[t] = 1; new_seq[t*SW +: SW] = nseq[t];
                end
                if ($urandom_range(0, 4) == 0) begin
                    ex_sq_vld[t] = 1;
                    ex_sq_seq[t*SW +: SW] = nseq[t] - 16'($urandom_range(0, 12)) + 16'($urandom_range(0, 3));
                    ex_incl_self[t] = 1'($urandom_range(0, 1));
                    ex_mispred[t]   = 1'($urandom_range(0, 1));
                    ex_taken[t]     = 1'($urandom_range(0, 1));
                    ex_cond_ds[t]   = 1'($urandom_range(0, 1));
                    ex_tgt_pc[t*PW +: PW] = $urandom;
                end
            end
            cyc();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule